// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master Sequencer

This block turns a single-cycle request into one complete transaction on a minimum-mode system bus with multiplexed address and data lines. The transaction can be a memory read, a memory write or an I/O read. The client pulses a request together with a transaction kind, a 20-bit address and a write byte. The sequencer then runs the bus cycle. When the cycle closes it pulses a done strobe and, for reads, presents the byte returned by the slave.

Each transaction has four parts:

- **Address phase.** The full address is driven, and its low byte goes out on the shared address/data lines.
- **Status phase.** A 3-bit status code names the cycle type. The write byte replaces the address on the shared lines, or, on reads, the drivers float.
- **Settle window.** A fixed number of clocks passes during which the slave's READY line is deliberately ignored. A slow slave may raise its not-ready flag late, and this window ensures that flag is seen.
- **READY wait.** The cycle is held open for as long as READY is low.

The idle status is restored in the clock that carries the done strobe.

Top module: `bus88_master_seq`

## Requirements
- R1: While reset is asserted and after it is released, status is idle (3'b111), done is low, the address latch strobe is low, the shared-line drivers are disabled and the read byte is zero.
- R2: A request is accepted on a clock edge where the block is idle. In the next clock the block drives the following signals, with status still idle:
  - address bits 19:16 on the high group;
  - address bits 15:8 on the middle group;
  - address bits 7:0 on the shared lines, with their drivers enabled;
  - the latch strobe, high.
- R3: Kind 2'b00 is a memory read with status 3'b101. Kind 2'b01 is a memory write with status 3'b110. Kind 2'b10 is an I/O read with status 3'b001. Kind 2'b11 behaves as an I/O read. The status code appears one clock after the address phase and holds until the done clock.
- R4: On a write, from the first status clock through the done clock, the shared lines carry the write byte with their drivers enabled.
- R5: On a read, the shared-line drivers are disabled from the first status clock through the done clock. The read byte is taken from the shared input lines on the edge where READY is first seen high, and it is held until the next read completes.
- R6: With settle parameter S (default 2), READY is ignored during the first S status clocks. It is first sampled at the end of status clock S+1. A high READY during the settle clocks does not shorten the cycle.
- R7: Each sampling edge on which READY is low adds one clock to the cycle. A cycle that sees W low samples lasts S+3+W clocks, counted from the address phase to the done clock.
- R8: Done is high for exactly one clock, the clock after READY is sampled high, and status is idle in that clock. The block is idle, and can accept a request, in the following clock.
- R9: A request raised while a transaction is in progress is ignored. The address groups and the status code do not change, and no address phase follows the done clock.
- R10: The high and middle address groups keep their values from the address phase through the done clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request, sampled while idle |
| kind_i | input | 2 | Transaction kind (see R3) |
| addr_i | input | 20 | Transaction address |
| wdata_i | input | 8 | Byte to write |
| done_o | output | 1 | One-clock completion strobe |
| rdata_o | output | 8 | Byte captured on the last read |
| bus_a_hi_o | output | 4 | Address bits 19:16 |
| bus_a_mid_o | output | 8 | Address bits 15:8 |
| bus_ad_o | output | 8 | Shared address/data lines, outgoing value |
| bus_ad_oe_o | output | 1 | Enable for the shared-line drivers |
| bus_ad_i | input | 8 | Shared address/data lines, incoming value |
| bus_ale_o | output | 1 | Address latch strobe, high in the address phase |
| bus_status_o | output | 3 | Cycle status code |
| bus_ready_i | input | 1 | Slave ready, low to insert wait states |

## Verification
Directed transactions of each kind with zero wait states fix the base cycle length and the status code for each kind. Across all transactions the slave model holds READY high during the settle clocks, so a sequencer that samples too early finishes before its expected done clock. Random mixes of kind, address, data and 0 to 6 wait states separate a correct wait-state count from one that is off by one. During not-ready clocks the slave drives scrambled bytes, and it drives the true byte only on the ready clock, so capture on the wrong edge shows up as bad read data. A second request raised in mid-cycle with a different address tells a sequencer that ignores it apart from one that restarts or relatches.

// File: rtl/bus88_seq_pkg.sv
package bus88_seq_pkg;

  typedef enum logic [1:0] {
    K_MEM_RD = 2'b00,
    K_MEM_WR = 2'b01,
    K_IO_RD  = 2'b10,
    K_ALT_IO = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    S_IO_RD  = 3'b001,
    S_MEM_RD = 3'b101,
    S_MEM_WR = 3'b110,
    S_IDLE   = 3'b111
  } status_e;

  typedef enum logic [2:0] {
    P_IDLE,
    P_ADDR,
    P_SETTLE,
    P_WAIT,
    P_END
  } phase_e;

  function automatic status_e status_of(kind_e k);
    case (k)
      K_MEM_RD: status_of = S_MEM_RD;
      K_MEM_WR: status_of = S_MEM_WR;
      default:  status_of = S_IO_RD;
    endcase
  endfunction

endpackage

// File: rtl/bus88_seq_ctrl.sv
module bus88_seq_ctrl
  import bus88_seq_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   ready_i,
  output phase_e phase_o,
  output logic   start_o,
  output logic   capture_o
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign start_o   = (phase_q == P_IDLE) && req_i;
  assign capture_o = (phase_q == P_WAIT) && ready_i;
  assign phase_o   = phase_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      P_IDLE:   if (req_i) phase_d = P_ADDR;
      P_ADDR: begin
        phase_d = P_SETTLE;
        cnt_d   = '0;
      end
      P_SETTLE: begin
        // ready deliberately ignored here
        if (cnt_q == CNT_LAST) phase_d = P_WAIT;
        else cnt_d = cnt_q + 1'b1;
      end
      P_WAIT:   if (ready_i) phase_d = P_END;
      P_END:    phase_d = P_IDLE;
      default:  phase_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= P_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  a_r6_no_exit_from_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == P_SETTLE) |=> (phase_q != P_END));

  a_r7_hold_while_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == P_WAIT && !ready_i) |=> (phase_q == P_WAIT));

  a_r9_no_restart_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != P_IDLE) |=> (phase_q != P_ADDR));

endmodule

// File: rtl/bus88_seq_drive.sv
module bus88_seq_drive
  import bus88_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int MID_W  = 8,
  localparam int HI_W  = ADDR_W - DATA_W - MID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  phase_e            phase_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HI_W-1:0]   a_hi_o,
  output logic [MID_W-1:0]  a_mid_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic [2:0]        status_o,
  output logic              is_read_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  kind_e             kind_q;
  logic              in_status, is_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      kind_q  <= K_MEM_RD;
    end else if (start_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      kind_q  <= kind_e'(kind_i);
    end
  end

  assign in_status = (phase_i == P_SETTLE) || (phase_i == P_WAIT);
  assign is_wr     = (kind_q == K_MEM_WR);
  assign is_read_o = !is_wr;

  assign a_hi_o   = addr_q[ADDR_W-1 -: HI_W];
  assign a_mid_o  = addr_q[DATA_W +: MID_W];
  assign ale_o    = (phase_i == P_ADDR);
  assign status_o = in_status ? status_of(kind_q) : S_IDLE;
  assign ad_oe_o  = (phase_i == P_ADDR) || (is_wr && (in_status || phase_i == P_END));
  assign ad_o     = (phase_i == P_ADDR) ? addr_q[DATA_W-1:0] : wdata_q;

  a_r2_ale_with_idle_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (status_o == S_IDLE) && ad_oe_o);

  a_r4_write_data_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == S_MEM_WR) |-> ad_oe_o && (ad_o == wdata_q));

endmodule

// File: rtl/bus88_seq_capture.sv
module bus88_seq_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              is_read_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (capture_i && is_read_i) rdata_o <= ad_i;
  end

  a_r5_hold_without_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(capture_i && is_read_i) |=> $stable(rdata_o));

endmodule

// File: rtl/bus88_master_seq.sv
module bus88_master_seq
  import bus88_seq_pkg::*;
#(
  parameter int SETTLE = 2,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int MID_W  = 8,
  localparam int HI_W  = ADDR_W - DATA_W - MID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [HI_W-1:0]   bus_a_hi_o,
  output logic [MID_W-1:0]  bus_a_mid_o,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe_o,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic              bus_ale_o,
  output logic [2:0]        bus_status_o,
  input  logic              bus_ready_i
);
  phase_e phase;
  logic   start, capture, is_read;

  bus88_seq_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk_i, .rst_ni, .req_i, .ready_i(bus_ready_i),
    .phase_o(phase), .start_o(start), .capture_o(capture)
  );

  bus88_seq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W)) u_drive (
    .clk_i, .rst_ni, .start_i(start), .phase_i(phase), .kind_i, .addr_i, .wdata_i,
    .a_hi_o(bus_a_hi_o), .a_mid_o(bus_a_mid_o), .ad_o(bus_ad_o), .ad_oe_o(bus_ad_oe_o),
    .ale_o(bus_ale_o), .status_o(bus_status_o), .is_read_o(is_read)
  );

  bus88_seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .capture_i(capture), .is_read_i(is_read), .ad_i(bus_ad_i),
    .rdata_o
  );

  assign done_o = (phase == P_END);

  a_r3_status_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_status_o != S_IDLE) |=> (bus_status_o == S_IDLE) || $stable(bus_status_o));

  a_r10_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_status_o != S_IDLE) |-> $stable(bus_a_mid_o) && $stable(bus_a_hi_o));

  a_r5_read_lines_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_status_o == S_MEM_RD || bus_status_o == S_IO_RD) |-> !bus_ad_oe_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_idle_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_status_o == S_IDLE));

endmodule

// File: tb/bus88_master_seq_bench.sv
module bus88_master_seq_bench;
  localparam int SETTLE = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, ready = 1'b1;
  logic [1:0]  kind = 2'b00;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0, ad_in = '0;
  logic        done, ad_oe, ale;
  logic [7:0]  rdata, ad_out, a_mid;
  logic [3:0]  a_hi;
  logic [2:0]  status;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus88_master_seq #(.SETTLE(SETTLE)) u_bus88_master_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .wdata_i(wdata), .done_o(done), .rdata_o(rdata), .bus_a_hi_o(a_hi),
    .bus_a_mid_o(a_mid), .bus_ad_o(ad_out), .bus_ad_oe_o(ad_oe), .bus_ad_i(ad_in),
    .bus_ale_o(ale), .bus_status_o(status), .bus_ready_i(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_status(input logic [1:0] k);
    case (k)
      2'b00:   return 3'b101;
      2'b01:   return 3'b110;
      default: return 3'b001;
    endcase
  endfunction

  task automatic run_txn(input logic [1:0] k, input logic [19:0] a, input logic [7:0] wd,
                         input int waits, input logic [7:0] sd, input bit poke);
    bit rd;
    rd = (k != 2'b01);
    @(negedge clk);
    req = 1; kind = k; addr = a; wdata = wd; ready = 1; ad_in = ~sd;
    @(negedge clk);
    req = 0;
    if (poke) begin req = 1; addr = ~a; kind = k ^ 2'b01; wdata = ~wd; end
    chk("R2 ale", ale, 1);
    chk("R2 status idle", status, 3'b111);
    chk("R2 addr hi", a_hi, a[19:16]);
    chk("R2 addr mid", a_mid, a[15:8]);
    chk("R2 addr low", ad_out, a[7:0]);
    chk("R2 oe", ad_oe, 1);
    for (int s = 0; s < SETTLE; s++) begin
      @(negedge clk);
      ready = 1; // early high must be ignored
      chk("R3 status", status, exp_status(k));
      chk("R6 no done in settle", done, 0);
      chk("R10 addr mid", a_mid, a[15:8]);
      chk("R9 addr hi", a_hi, a[19:16]);
      if (rd) chk("R5 oe low", ad_oe, 0);
      else begin chk("R4 oe", ad_oe, 1); chk("R4 data", ad_out, wd); end
    end
    for (int j = 0; j <= waits; j++) begin
      @(negedge clk);
      chk("R7 status", status, exp_status(k));
      chk("R7 no done", done, 0);
      ready = (j == waits);
      ad_in = (j == waits) ? sd : 8'($urandom) ^ 8'h5a;
      if (j != waits && ad_in == sd) ad_in = ~sd;
    end
    @(negedge clk);
    req = 0;
    chk("R8 done", done, 1);
    chk("R8 status idle", status, 3'b111);
    chk("R10 addr mid at done", a_mid, a[15:8]);
    if (rd) chk("R5 rdata", rdata, sd);
    else chk("R4 data at done", ad_out, wd);
    ad_in = ~sd;
    @(negedge clk);
    chk("R8 done one clock", done, 0);
    chk("R9 no new addr phase", ale, 0);
    if (rd) chk("R5 rdata held", rdata, sd);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_rd;
    void'($urandom(32'd20170211));
    #1;
    chk("R1 status in reset", status, 3'b111);
    chk("R1 done in reset", done, 0);
    chk("R1 oe in reset", ad_oe, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 3'b111);
    chk("R1 ale", ale, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 done", done, 0);

    run_txn(2'b00, 20'hA_5C3E, 8'h00, 0, 8'h3C, 0);
    run_txn(2'b01, 20'h0_00FF, 8'hC7, 0, 8'h00, 0);
    run_txn(2'b10, 20'hF_FFFF, 8'h00, 0, 8'hE1, 0);
    run_txn(2'b11, 20'h1_2345, 8'h00, 3, 8'h96, 0);
    run_txn(2'b01, 20'h8_0001, 8'h5A, 6, 8'h00, 1);
    run_txn(2'b00, 20'h7_7000, 8'h00, 2, 8'h81, 1);
    last_rd = 8'h81;
    // a write must leave the read byte alone
    run_txn(2'b01, 20'h3_1111, 8'h22, 1, 8'hFF, 0);
    chk("R5 rdata unchanged by write", rdata, last_rd);

    for (int i = 0; i < 40; i++) begin
      run_txn(2'($urandom), 20'($urandom), 8'($urandom), int'($urandom % 7),
              8'($urandom), bit'($urandom));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule